// File: doc/BRIEF.md
# Deglitched Power-Good Monitor

This block decides whether a regulator's open-drain power-good pin should be released (high impedance) or pulled low. It works from already digitised comparator flags and never sees analog levels. One flag says the feedback voltage is above the upper trip point, 92.5% of the reference. A second says it is below the lower trip point, 90% of the reference. A third says the reference itself is above 0.54 V. Three fault flags (shutdown, undervoltage lockout, thermal shutdown) and a one-cycle tick from the switching oscillator complete the inputs.

A low-to-released change needs the feedback above the upper trip point with a valid reference. A released-to-low change needs the feedback below the lower trip point or an invalid reference. Either change takes effect only after its condition has held across a fixed number of oscillator ticks. Between the two trip points the block keeps its present state. Any fault flag pulls the request low in the same cycle, with no deglitch. The monitor has no data stream, so every pin is a plain level signal.

Top module: `pg_monitor`

## Requirements
- R1: While reset is asserted and right after it, `pg_rel_o` is 0 (pull low). Encoding: 1 = release the pin, 0 = pull it low.
- R2: From the pulled-low state, `pg_rel_o` goes to 1 on the clock edge that samples the QUAL_TICKS-th tick (default 48). Every cycle from the first counted tick through that edge must have `fb_hi_i`=1 and `ref_ok_i`=1 and no fault flag.
- R3: With `ref_ok_i`=0, `pg_rel_o` never goes to 1, however long `fb_hi_i` stays high.
- R4: From the released state, `fb_lo_i`=1 held across QUAL_TICKS ticks sets `pg_rel_o` to 0 on the edge that samples the last of those ticks.
- R5: From the released state, `ref_ok_i`=0 held across QUAL_TICKS ticks sets `pg_rel_o` to 0, even if `fb_hi_i`=1.
- R6: With `fb_hi_i`=0 and `fb_lo_i`=0 (inside the hysteresis band), the state does not change, in either state.
- R7: If the pending condition drops for even one clock before the count completes, the count restarts from zero, and a full QUAL_TICKS ticks are needed again.
- R8: While `shdn_i`, `uvlo_i` or `tsd_i` is 1, `pg_rel_o` is 0 in that same cycle (combinational), and the state is cleared to pulled low.
- R9: After a fault flag clears, `pg_rel_o` stays 0 until a complete qualified rise per R2 finishes.
- R10: Clock cycles without `tick_i` do not advance the count. A held condition without ticks never changes the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle pulse per switching period |
| fb_hi_i | input | 1 | Feedback above 92.5% of reference |
| fb_lo_i | input | 1 | Feedback below 90% of reference |
| ref_ok_i | input | 1 | Reference above 0.54 V |
| shdn_i | input | 1 | Shutdown active |
| uvlo_i | input | 1 | Supply undervoltage lockout active |
| tsd_i | input | 1 | Thermal shutdown active |
| pg_rel_o | output | 1 | 1 = release pin, 0 = pull pin low |

## Verification
The embedded assertions check the following on every cycle:
- the tick counter stays in range;
- the counter returns to zero whenever the pending condition drops;
- the counter stays still on cycles without a tick;
- a fault clears the state on the next edge;
- every change of state is preceded by its proper qualifying condition.

The exact edge at which the output changes can only be shown by the bench scenarios. The same holds for the band between the trip points holding both states, for a restart after a one-cycle interruption, and for the combinational pull-low while a fault is present.

// File: rtl/pg_monitor_pkg.sv
package pg_monitor_pkg;
  typedef enum logic {
    PG_LOW      = 1'b0,
    PG_RELEASED = 1'b1
  } pg_state_e;
endpackage

// File: rtl/pg_cond_decode.sv
module pg_cond_decode #(
  parameter int NUM_FAULTS = 3
) (
  input  logic                  fb_hi_i,
  input  logic                  fb_lo_i,
  input  logic                  ref_ok_i,
  input  logic [NUM_FAULTS-1:0] fault_i,
  output logic                  force_low_o,
  output logic                  rise_ok_o,
  output logic                  fall_req_o
);
  // Any fault source forces the request low with no qualification.
  assign force_low_o = |fault_i;
  // Rise needs upper trip and valid reference; fall on lower trip or lost reference.
  assign rise_ok_o   = fb_hi_i & ref_ok_i;
  assign fall_req_o  = fb_lo_i | ~ref_ok_i;
endmodule

// File: rtl/pg_deglitch.sv
module pg_deglitch #(
  parameter int QUAL_TICKS = 48
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic pend_i,
  input  logic tick_i,
  output logic done_o
);
  localparam int CW = (QUAL_TICKS > 2) ? $clog2(QUAL_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(QUAL_TICKS - 1);

  logic [CW-1:0] cnt_q;

  assign done_o = pend_i & tick_i & ~clear_i & (cnt_q == LAST);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clear_i || !pend_i || done_o) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  a_r7_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);

  a_r7_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_i |=> (cnt_q == '0));

  a_r10_no_tick_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_i && !tick_i && !clear_i) |=> $stable(cnt_q));
endmodule

// File: rtl/pg_state_track.sv
module pg_state_track
  import pg_monitor_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic force_low_i,
  input  logic rise_ok_i,
  input  logic fall_req_i,
  input  logic done_i,
  output logic pend_o,
  output logic pg_rel_o
);
  pg_state_e st_q;

  // The condition being qualified depends on the present state (hysteresis).
  assign pend_o   = (st_q == PG_RELEASED) ? fall_req_i : rise_ok_i;
  assign pg_rel_o = (st_q == PG_RELEASED) & ~force_low_i;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      st_q <= PG_LOW;
    end else if (force_low_i) begin
      st_q <= PG_LOW;
    end else if (done_i) begin
      st_q <= (st_q == PG_LOW) ? PG_RELEASED : PG_LOW;
    end
  end

  a_r8_force_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_low_i |=> (st_q == PG_LOW));

  a_r2_rise_qualified: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(st_q == PG_RELEASED) |-> $past(rise_ok_i && done_i && !force_low_i));

  a_r4_fall_qualified: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(st_q == PG_RELEASED) |-> $past(force_low_i || (fall_req_i && done_i)));
endmodule

// File: rtl/pg_monitor.sv
module pg_monitor #(
  parameter int QUAL_TICKS = 48
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic fb_hi_i,
  input  logic fb_lo_i,
  input  logic ref_ok_i,
  input  logic shdn_i,
  input  logic uvlo_i,
  input  logic tsd_i,
  output logic pg_rel_o
);
  localparam int NUM_FAULTS = 3;

  logic [NUM_FAULTS-1:0] fault_vec;
  logic force_low, rise_ok, fall_req, pend, done;

  assign fault_vec = {tsd_i, uvlo_i, shdn_i};

  pg_cond_decode #(.NUM_FAULTS(NUM_FAULTS)) u_decode (
    .fb_hi_i     (fb_hi_i),
    .fb_lo_i     (fb_lo_i),
    .ref_ok_i    (ref_ok_i),
    .fault_i     (fault_vec),
    .force_low_o (force_low),
    .rise_ok_o   (rise_ok),
    .fall_req_o  (fall_req)
  );

  pg_deglitch #(.QUAL_TICKS(QUAL_TICKS)) u_deglitch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (force_low),
    .pend_i  (pend),
    .tick_i  (tick_i),
    .done_o  (done)
  );

  pg_state_track u_state (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .force_low_i (force_low),
    .rise_ok_i   (rise_ok),
    .fall_req_i  (fall_req),
    .done_i      (done),
    .pend_o      (pend),
    .pg_rel_o    (pg_rel_o)
  );
endmodule

// File: tb/pg_monitor_tb_top.sv
`timescale 1ns/1ps
module pg_monitor_tb_top;
  localparam int QUAL = 48;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_ni = 1'b0;
  logic tick = 1'b0, fb_hi = 1'b0, fb_lo = 1'b0, ref_ok = 1'b0;
  logic shdn = 1'b0, uvlo = 1'b0, tsd = 1'b0;
  logic pg_rel;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic  exp;
    string tag;
  } item_t;
  item_t q[$];

  logic m_st  = 1'b0;
  int   m_cnt = 0;

  pg_monitor #(.QUAL_TICKS(QUAL)) dut_i (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .fb_hi_i  (fb_hi),
    .fb_lo_i  (fb_lo),
    .ref_ok_i (ref_ok),
    .shdn_i   (shdn),
    .uvlo_i   (uvlo),
    .tsd_i    (tsd),
    .pg_rel_o (pg_rel)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: pg_rel actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // Driver: apply one cycle of inputs, update the requirement model,
  // and queue the output expected after the next rising edge.
  task automatic drive(input logic hi, input logic lo, input logic rf,
                       input logic sh, input logic uv, input logic ts,
                       input logic tk, input string tag);
    logic frc;
    logic pend;
    @(negedge clk);
    fb_hi = hi; fb_lo = lo; ref_ok = rf;
    shdn = sh; uvlo = uv; tsd = ts; tick = tk;
    frc = sh | uv | ts;
    if (frc) begin
      m_st = 1'b0; m_cnt = 0;
    end else begin
      pend = m_st ? (lo | ~rf) : (hi & rf);
      if (!pend) m_cnt = 0;
      else if (tk) begin
        if (m_cnt == QUAL - 1) begin
          m_st = ~m_st; m_cnt = 0;
        end else m_cnt++;
      end
    end
    q.push_back('{exp: m_st & ~frc, tag: tag});
  endtask

  task automatic hold(input int n, input logic hi, input logic lo, input logic rf,
                      input logic tk, input string tag);
    for (int i = 0; i < n; i++) drive(hi, lo, rf, 1'b0, 1'b0, 1'b0, tk, tag);
  endtask

  // Monitor: compare after every rising edge
  always @(posedge clk) begin
    item_t it;
    #1;
    if (q.size() > 0) begin
      it = q.pop_front();
      chk(pg_rel, it.exp, it.tag);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 chk(pg_rel, 1'b0, "R1 during reset");
    @(negedge clk); rst_ni = 1'b1;
    #1 chk(pg_rel, 1'b0, "R1 after reset");

    // R3: no valid reference, no release
    hold(QUAL + 20, 1'b1, 1'b0, 1'b0, 1'b1, "R3 ref invalid");
    // R7: interrupted rise restarts the count
    hold(QUAL - 1, 1'b1, 1'b0, 1'b1, 1'b1, "R7 partial rise");
    hold(1, 1'b0, 1'b0, 1'b1, 1'b1, "R7 break");
    hold(QUAL - 1, 1'b1, 1'b0, 1'b1, 1'b1, "R7 restarted count");
    hold(1, 1'b1, 1'b0, 1'b1, 1'b1, "R2 release on last tick");
    // R6: band keeps released
    hold(QUAL + 10, 1'b0, 1'b0, 1'b1, 1'b1, "R6 band held high");
    // R10: no ticks, no fall
    hold(QUAL + 10, 1'b0, 1'b1, 1'b1, 1'b0, "R10 no tick");
    // R4: lower trip qualified fall
    hold(QUAL, 1'b0, 1'b1, 1'b1, 1'b1, "R4 fall on low feedback");
    // R6: band keeps low
    hold(QUAL + 10, 1'b0, 1'b0, 1'b1, 1'b1, "R6 band held low");
    // R2 rise with sparse ticks
    for (int i = 0; i < QUAL; i++) begin
      hold(1, 1'b1, 1'b0, 1'b1, 1'b0, "R10 idle cycle");
      hold(1, 1'b1, 1'b0, 1'b1, 1'b1, "R2 sparse ticks");
    end
    // R5: reference loss qualified fall
    hold(QUAL, 1'b1, 1'b0, 1'b0, 1'b1, "R5 fall on reference loss");
    hold(5, 1'b1, 1'b0, 1'b1, 1'b1, "R5 recovery start");

    // R8, R9 for each fault source
    for (int f = 0; f < 3; f++) begin
      hold(QUAL, 1'b1, 1'b0, 1'b1, 1'b1, "R2 rise before fault");
      drive(1'b1, 1'b0, 1'b1, f == 0, f == 1, f == 2, 1'b1, "R8 fault cycle");
      #1 chk(pg_rel, 1'b0, "R8 immediate pull low");
      drive(1'b1, 1'b0, 1'b1, f == 0, f == 1, f == 2, 1'b1, "R8 fault held");
      hold(QUAL - 1, 1'b1, 1'b0, 1'b1, 1'b1, "R9 low after fault");
      hold(1, 1'b1, 1'b0, 1'b1, 1'b1, "R9 full qualified rise");
      hold(QUAL, 1'b0, 1'b1, 1'b1, 1'b1, "R4 fall between faults");
    end

    @(posedge clk);
    @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule